// File: doc/BRIEF.md
# Cursor Address Counter and Display RAM Access Sequencer

This block holds a 16-bit cursor address that selects one byte of an external byte-wide display RAM. The host sets the address as two separate bytes and then issues access commands: store a byte, fetch a byte, or force one bit of a byte to 0 or 1. Each access uses the current cursor address and then advances the cursor by one. The address wraps from the top of the space back to zero.

A single-bit operation is a read-modify-write. The block fetches the addressed byte, patches the selected bit and stores the result at the same address. The block drives a simple memory request interface with an address, write data, a write strobe and a read strobe. The RAM must return read data one clock after the read strobe. While an access is running the block reports busy and ignores any command.

Top module: `cursor_mem_engine`

## Requirements
- R1: After reset the cursor address is 0x0000, busy is low and neither memory strobe is active.
- R2: The low-byte load opcode is 0. It replaces the low byte with cmd_data. If bit 7 of the old low byte is 1 and bit 7 of the new value is 0, the high byte increments by one in the same update. Otherwise the high byte is unchanged.
- R3: The high-byte load opcode is 1. It replaces the high byte with cmd_data and leaves the low byte unchanged.
- R4: The byte write opcode is 2. It produces exactly one write strobe carrying cmd_data, with mem_addr equal to the cursor address at the time the command was accepted.
- R5: The byte read opcode is 3. It produces one read strobe at the cursor address. Two cycles after the strobe, the byte the RAM returned appears on rd_data with a one-cycle rd_valid pulse.
- R6: Every write, read, bit-clear and bit-set advances the cursor by exactly one when it finishes. 0xFFFF advances to 0x0000.
- R7: The bit-clear opcode is 4 and the bit-set opcode is 5. cmd_data[2:0] gives the bit number, where 0 is the LSB and 7 is the MSB, and cmd_data[7:3] is ignored. The addressed byte is read and then written back to the same address with only that bit forced to 0 (clear) or 1 (set).
- R8: A command is accepted only while busy is low. Busy then stays high for 2 cycles for a write, 3 for a read and 5 for a bit operation. Commands presented while busy have no effect on the cursor or the memory.
- R9: The write strobe and read strobe are never active together, and neither is active while busy is low.
- R10: Opcodes 6 and 7 are ignored: the cursor, busy and the memory strobes do not respond to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 8 | Command operand: address byte, write data or bit number |
| busy | output | 1 | An access is in progress; commands are ignored |
| cur_addr | output | 16 | Current cursor address |
| rd_data | output | 8 | Last byte fetched by a read command |
| rd_valid | output | 1 | One-cycle pulse when rd_data is updated |
| mem_addr | output | 16 | RAM address, always the cursor address |
| mem_wdata | output | 8 | RAM write data |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe; data is expected one clock later |
| mem_rdata | input | 8 | RAM read data |

## Verification
Two updates can compete for the cursor in the same cycle: the increment that ends an access, and a host address load. To provoke this, the bench keeps a high-byte load asserted on the command inputs for every cycle of a write, including the final increment cycle. It then checks that the cursor is exactly one above its start value and that exactly one RAM write took place. A second case lets the increment carry across the 0xFFFF boundary. Low-byte loads are judged separately for the bit-7 falling carry into the high byte.

// File: rtl/curs_pkg.sv
`timescale 1ns/1ps
package curs_pkg;

  typedef enum logic [2:0] {
    OP_LOAD_LO = 3'd0,
    OP_LOAD_HI = 3'd1,
    OP_WRITE   = 3'd2,
    OP_READ    = 3'd3,
    OP_BIT_CLR = 3'd4,
    OP_BIT_SET = 3'd5
  } host_op_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_WAIT   = 3'd2,
    ST_MODIFY = 3'd3,
    ST_STORE  = 3'd4,
    ST_BUMP   = 3'd5
  } seq_state_e;

endpackage

// File: rtl/cursor_counter.sv
`timescale 1ns/1ps
module cursor_counter #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic              bump,
  input  logic [BYTE_W-1:0] din,
  output logic [ADDR_W-1:0] addr
);
  localparam int HI_W = ADDR_W - BYTE_W;

  logic [BYTE_W-1:0] lo_q, lo_n;
  logic [HI_W-1:0]   hi_q, hi_n;
  logic              cnt_en;

  assign cnt_en = bump | load_lo | load_hi;

  // Next-value selection: increment outranks loads (loads only arrive when idle)
  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    if (bump) begin
      {hi_n, lo_n} = {hi_q, lo_q} + ADDR_W'(1);
    end else if (load_lo) begin
      lo_n = din;
      // falling MSB of the low byte ripples into the high byte
      if (lo_q[BYTE_W-1] && !din[BYTE_W-1]) begin
        hi_n = hi_q + HI_W'(1);
      end
    end else if (load_hi) begin
      hi_n = HI_W'(din);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (cnt_en) begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign addr = {hi_q, lo_q};
endmodule

// File: rtl/bit_patch.sv
`timescale 1ns/1ps
module bit_patch #(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic [BYTE_W-1:0] byte_in,
  input  logic [SEL_W-1:0]  sel,
  input  logic              set_val,
  output logic [BYTE_W-1:0] byte_out
);
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign byte_out[i] = (sel == SEL_W'(i)) ? set_val : byte_in[i];
  end
endmodule

// File: rtl/access_seq.sv
`timescale 1ns/1ps
module access_seq
  import curs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              busy,
  output logic              load_lo,
  output logic              load_hi,
  output logic              bump,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int SEL_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  seq_state_e        st_q, st_n;
  host_op_e          op;
  logic              accept;
  logic              start_bit;
  logic              bit_q, set_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BYTE_W-1:0] buf_q, buf_n, patched;
  logic              buf_en;
  logic              rd_en;
  logic [BYTE_W-1:0] rd_data_q;
  logic              rd_valid_q;

  assign op        = host_op_e'(cmd_op);
  assign accept    = cmd_valid && (st_q == ST_IDLE);
  assign start_bit = accept && ((op == OP_BIT_CLR) || (op == OP_BIT_SET));

  assign load_lo = accept && (op == OP_LOAD_LO);
  assign load_hi = accept && (op == OP_LOAD_HI);

  // next state
  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          case (op)
            OP_WRITE:   st_n = ST_STORE;
            OP_READ:    st_n = ST_FETCH;
            OP_BIT_CLR: st_n = ST_FETCH;
            OP_BIT_SET: st_n = ST_FETCH;
            default:    st_n = ST_IDLE;
          endcase
        end
      end
      ST_FETCH:  st_n = ST_WAIT;
      ST_WAIT:   st_n = bit_q ? ST_MODIFY : ST_BUMP;
      ST_MODIFY: st_n = ST_STORE;
      ST_STORE:  st_n = ST_BUMP;
      ST_BUMP:   st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_n;
  end

  // operation attributes latched on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      set_q <= 1'b0;
      sel_q <= '0;
    end else if (accept) begin
      bit_q <= start_bit;
      set_q <= (op == OP_BIT_SET);
      sel_q <= cmd_data[SEL_W-1:0];
    end
  end

  bit_patch #(
    .BYTE_W (BYTE_W),
    .SEL_W  (SEL_W)
  ) u_patch (
    .byte_in  (buf_q),
    .sel      (sel_q),
    .set_val  (set_q),
    .byte_out (patched)
  );

  // data buffer: write operand, fetched byte, then patched byte
  always_comb begin
    buf_en = 1'b0;
    buf_n  = buf_q;
    if (accept && (op == OP_WRITE)) begin
      buf_en = 1'b1;
      buf_n  = cmd_data;
    end else if (st_q == ST_WAIT) begin
      buf_en = 1'b1;
      buf_n  = mem_rdata;
    end else if (st_q == ST_MODIFY) begin
      buf_en = 1'b1;
      buf_n  = patched;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_n;
  end

  assign rd_en = (st_q == ST_WAIT) && !bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en) rd_data_q <= mem_rdata;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign mem_re    = (st_q == ST_FETCH);
  assign mem_we    = (st_q == ST_STORE);
  assign bump      = (st_q == ST_BUMP);
  assign mem_wdata = buf_q;
  assign rd_data   = rd_data_q;
  assign rd_valid  = rd_valid_q;
endmodule

// File: rtl/cursor_mem_engine.sv
`timescale 1ns/1ps
module cursor_mem_engine #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic rst_meta, rst_sync;
  logic load_lo, load_hi, bump;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  access_seq #(
    .BYTE_W (BYTE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_data  (cmd_data),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .load_lo   (load_lo),
    .load_hi   (load_hi),
    .bump      (bump),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  cursor_counter #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync),
    .load_lo (load_lo),
    .load_hi (load_hi),
    .bump    (bump),
    .din     (cmd_data),
    .addr    (cur_addr)
  );

  assign mem_addr = cur_addr;
endmodule

// File: rtl/cursor_mem_engine_chk.sv
`timescale 1ns/1ps
module cursor_mem_engine_chk
  import curs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              rd_valid,
  input logic              mem_we,
  input logic              mem_re
);
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  assert_strobe_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);

  assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

  assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && (cmd_op == OP_LOAD_HI)) |=> (cur_addr[7:0] == $past(cur_addr[7:0])));

  assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(mem_re, 2));

  assert_fetch_then_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (busy && !mem_we && !mem_re));

  assert_store_then_bump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (busy && !mem_we && $stable(cur_addr)));
endmodule

bind cursor_mem_engine cursor_mem_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .cur_addr  (cur_addr),
  .rd_valid  (rd_valid),
  .mem_we    (mem_we),
  .mem_re    (mem_re)
);

// File: tb/cursor_mem_engine_test.sv
`timescale 1ns/1ps
module cursor_mem_engine_test;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_op;
  logic [7:0]  cmd_data;
  logic        busy;
  logic [15:0] cur_addr;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [7:0]  mem_rdata;

  int n_chk = 0;
  int n_err = 0;
  int we_count = 0;
  int strobe_bad = 0;
  logic [15:0] last_waddr;
  logic [7:0]  last_wdata;
  logic [7:0]  ram [256];

  cursor_mem_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .cur_addr(cur_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // RAM model with one-cycle read latency, folded index
  always @(posedge clk) begin
    if (mem_we) begin
      ram[mem_addr[7:0] ^ mem_addr[15:8]] <= mem_wdata;
      last_waddr <= mem_addr;
      last_wdata <= mem_wdata;
      we_count   <= we_count + 1;
    end
    if (mem_re) mem_rdata <= ram[mem_addr[7:0] ^ mem_addr[15:8]];
    if (rst_n && ((mem_we && mem_re) || ((mem_we || mem_re) && !busy)))
      strobe_bad <= strobe_bad + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // issue one command; returns busy-cycle count and last read byte
  task automatic issue(input logic [2:0] op, input logic [7:0] d,
                       output int busy_cyc, output logic [7:0] rv);
    busy_cyc = 0;
    rv = 8'hxx;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (rd_valid) rv = rd_data;
      if (!busy) break;
      busy_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic set_addr(input logic [15:0] a);
    int bc; logic [7:0] rv;
    issue(3'd0, a[7:0], bc, rv);
    issue(3'd1, a[15:8], bc, rv);
  endtask

  task automatic t_reset;
    chk("R1 cursor", cur_addr, 16'h0000);
    chk("R1 busy", busy, 1'b0);
    chk("R1 strobes", {mem_we, mem_re}, 2'b00);
  endtask

  task automatic t_loads;
    int bc; logic [7:0] rv;
    set_addr(16'h1234);
    chk("R3 two-byte load", cur_addr, 16'h1234);
    issue(3'd1, 8'h56, bc, rv);
    chk("R3 high only keeps low", cur_addr, 16'h5634);
    issue(3'd0, 8'h80, bc, rv);
    chk("R2 rising msb no carry", cur_addr, 16'h5680);
    issue(3'd0, 8'h7F, bc, rv);
    chk("R2 falling msb carries", cur_addr, 16'h577F);
    issue(3'd0, 8'hFF, bc, rv);
    chk("R2 rising msb no carry 2", cur_addr, 16'h57FF);
    issue(3'd0, 8'h00, bc, rv);
    chk("R2 falling msb to zero", cur_addr, 16'h5800);
    chk("R2 loads not busy", bc, 0);
  endtask

  task automatic t_write;
    int bc; logic [7:0] rv; int wc0;
    set_addr(16'h0100);
    wc0 = we_count;
    issue(3'd2, 8'hA5, bc, rv);
    chk("R4 one write", we_count - wc0, 1);
    chk("R4 write addr", last_waddr, 16'h0100);
    chk("R4 write data", last_wdata, 8'hA5);
    chk("R6 write advances", cur_addr, 16'h0101);
    chk("R8 write busy cycles", bc, 2);
  endtask

  task automatic t_read;
    int bc; logic [7:0] rv;
    set_addr(16'h0100);
    issue(3'd3, 8'h00, bc, rv);
    chk("R5 read data", rv, 8'hA5);
    chk("R6 read advances", cur_addr, 16'h0101);
    chk("R8 read busy cycles", bc, 3);
  endtask

  task automatic t_bits;
    int bc; logic [7:0] rv; int wc0;
    set_addr(16'h0200);
    issue(3'd2, 8'h0F, bc, rv);
    set_addr(16'h0200);
    wc0 = we_count;
    issue(3'd5, 8'hF7, bc, rv);
    chk("R7 set writes once", we_count - wc0, 1);
    chk("R7 set addr", last_waddr, 16'h0200);
    chk("R7 set msb", last_wdata, 8'h8F);
    chk("R6 bit op advances", cur_addr, 16'h0201);
    chk("R8 bit busy cycles", bc, 5);
    set_addr(16'h0200);
    issue(3'd4, 8'h08, bc, rv);
    chk("R7 clear lsb upper ignored", last_wdata, 8'h8E);
    set_addr(16'h0200);
    issue(3'd3, 8'h00, bc, rv);
    chk("R7 readback", rv, 8'h8E);
  endtask

  task automatic t_wrap;
    int bc; logic [7:0] rv;
    set_addr(16'hFFFF);
    issue(3'd2, 8'h3C, bc, rv);
    chk("R6 write at top", last_waddr, 16'hFFFF);
    chk("R6 wrap to zero", cur_addr, 16'h0000);
  endtask

  task automatic t_busy_ignore;
    int wc0; int bc;
    set_addr(16'h0300);
    wc0 = we_count;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 3'd2; cmd_data = 8'h11;
    @(negedge clk);
    cmd_op = 3'd1; cmd_data = 8'h77;   // held through the increment cycle
    bc = 0;
    while (busy && bc < 20) begin bc++; @(negedge clk); end
    cmd_valid = 1'b0;
    @(negedge clk);
    chk("R8 load ignored while busy", cur_addr, 16'h0301);
    chk("R8 single write", we_count - wc0, 1);
    chk("R8 write data kept", last_wdata, 8'h11);
  endtask

  task automatic t_unused;
    int wc0; int bc; logic [7:0] rv;
    set_addr(16'h4444);
    wc0 = we_count;
    issue(3'd6, 8'hAA, bc, rv);
    issue(3'd7, 8'h55, bc, rv);
    chk("R10 cursor unchanged", cur_addr, 16'h4444);
    chk("R10 no busy", bc, 0);
    chk("R10 no write", we_count - wc0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL R8 watchdog expired actual hung expected idle");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_data = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_loads;
    t_write;
    t_read;
    t_bits;
    t_wrap;
    t_busy_ignore;
    t_unused;
    chk("R9 strobe rules", strobe_bad, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule